// File: doc/BRIEF.md
# Fracturable Eight-Input Lookup Table

This block is a configurable logic cell for a programmable fabric. It holds a 64-bit truth-table mask and a 3-bit mode code. The mode decides how the mask and the eight data inputs `din[7:0]` split into one or two lookup functions. The cell always drives two combinational outputs and two registered copies of them.

The one mask store is read by two select trees. Each tree addresses the full mask, and a per-mode input router fixes the upper address bits so that each function lands in its own region. The same router gives each function its pins, which may be private or shared with the other function.

Configuration is loaded serially while the cell is held idle. While `cfg_en` is high, the cell takes one bit of `cfg_din` per clock, 67 bits in all:
- mask bit 0 comes first;
- mask bit 63 follows the other mask bits;
- the three mode bits come last, mode bit 0 first.

Top module: `frac_lut8`

## Requirements
- R1: While `cfg_en` is high, one bit of `cfg_din` is shifted in per rising edge. After 67 bits, the first bit sent is mask bit 0, bit 63 is the 64th bit sent, and mode bits 0..2 are bits 65..67 sent. While `cfg_en` is low, the stored mask and mode never change.
- R2: A table index is formed with the lowest-numbered routed pin as its least significant bit. In dual 4-input mode (code 1), loading mask bits 15:0 = 0x8009 makes `comb_o[0]` equal to a'b'c'd' + abcd + abc'd', where a=din[0], b=din[1], c=din[2] and d=din[3].
- R3: Mode 0 (full 6-input) sets `comb_o[0]` = mask[din[5:0]] and `comb_o[1]` = 0.
- R4: Mode 1 (dual 4-input) sets `comb_o[0]` = mask[din[3:0]] and `comb_o[1]` = mask[32 + din[7:4]].
- R5: Mode 2 (5+3) sets `comb_o[0]` = mask[din[4:0]] and `comb_o[1]` = mask[32 + din[7:5]].
- R6: Mode 3 (5+4, din[7] shared) sets `comb_o[0]` = mask[{din[7],din[3:0]}] and `comb_o[1]` = mask[32 + {din[7],din[6:4]}].
- R7: Mode 4 (dual 5-input, din[7:6] shared) sets `comb_o[0]` = mask[{din[7:6],din[2:0]}] and `comb_o[1]` = mask[32 + {din[7:6],din[5:3]}].
- R8: Mode 5 (twin 6-input, din[3:0] shared) sets `comb_o[0]` = mask[{din[5:4],din[3:0]}] and `comb_o[1]` = mask[{din[7:6],din[3:0]}].
- R9: Mode codes 6 and 7 drive both combinational outputs to 0. A synchronous reset (`rst` high at a rising edge) clears the mask to 0 and sets the mode to 7.
- R10: `reg_o` is cleared by reset. Otherwise it loads `comb_o` at a rising edge when `ce` is 1 and `cfg_en` is 0, and holds at every other edge, including every edge during loading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Serial configuration shift enable |
| cfg_din | input | 1 | Serial configuration data, mask then mode, LSB first |
| ce | input | 1 | Clock enable of the two output registers |
| din | input | 8 | Data inputs of the cell |
| comb_o | output | 2 | Combinational outputs of function 0 and function 1 |
| reg_o | output | 2 | Registered outputs of function 0 and function 1 |

## Verification
The bench targets the following mistakes and the symptoms each one produces:
- **Pin-to-address routing.** Every mode is swept over all 256 input patterns with several random masks. A shared pin wired to the wrong address bit, or a function placed in the wrong half of the mask, gives mismatches on one output in that mode only.
- **Mask bit order.** The 0x8009 case ties bit order to a known Boolean function, so a mask read in reverse order fails it.
- **Unused mode codes and reset.** Codes 6 and 7, and the state just after reset, must give zero outputs, which catches a decoder that falls through to another mode.
- **Register control.** The registers are checked every cycle against random `ce`, and throughout each serial load, so a register that captures while the cell is being configured shows a stale or changed value.

// File: rtl/frac_lut8_pkg.sv
package frac_lut8_pkg;

    localparam int LUT_K   = 6;
    localparam int MASK_W  = 1 << LUT_K;
    localparam int NUM_IN  = 8;
    localparam int MODE_W  = 3;
    localparam int CFG_W   = MASK_W + MODE_W;
    localparam int NUM_OUT = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_L6    = 3'd0,
        MODE_DUAL4 = 3'd1,
        MODE_L5L3  = 3'd2,
        MODE_L5L4  = 3'd3,
        MODE_DUAL5 = 3'd4,
        MODE_TWIN6 = 3'd5,
        MODE_OFF6  = 3'd6,
        MODE_OFF7  = 3'd7
    } lut_mode_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [MASK_W-1:0] mask;
    } lut_cfg_t;

    typedef struct packed {
        logic [NUM_OUT-1:0] reg_out;
    } lut_regs_t;

endpackage

// File: rtl/frac_lut8_cfg.sv
module frac_lut8_cfg
    import frac_lut8_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_en,
    input  logic     cfg_din,
    output lut_cfg_t cfg
);

    lut_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (rst) begin
            cfg_d.mask = '0;
            cfg_d.mode = MODE_OFF7;
        end else if (cfg_en) begin
            cfg_d = lut_cfg_t'({cfg_din, cfg_q[CFG_W-1:1]});
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(cfg_q)); // R1

    AST_CFG_NEW_MSB: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> (cfg_q.mode[MODE_W-1] == $past(cfg_din))); // R1

endmodule

// File: rtl/frac_lut8_route.sv
module frac_lut8_route
    import frac_lut8_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [NUM_IN-1:0] din,
    output logic [LUT_K-1:0]  idx_lo,
    output logic [LUT_K-1:0]  idx_hi,
    output logic              en_lo,
    output logic              en_hi
);

    always_comb begin
        idx_lo = '0;
        idx_hi = '0;
        en_lo  = 1'b0;
        en_hi  = 1'b0;
        unique case (mode)
            MODE_L6: begin
                idx_lo = din[5:0];
                en_lo  = 1'b1;
            end
            MODE_DUAL4: begin
                idx_lo = {2'b00, din[3:0]};
                idx_hi = {2'b10, din[7:4]};
                en_lo  = 1'b1;
                en_hi  = 1'b1;
            end
            MODE_L5L3: begin
                idx_lo = {1'b0, din[4:0]};
                idx_hi = {3'b100, din[7:5]};
                en_lo  = 1'b1;
                en_hi  = 1'b1;
            end
            MODE_L5L4: begin
                idx_lo = {1'b0, din[7], din[3:0]};
                idx_hi = {2'b10, din[7], din[6:4]};
                en_lo  = 1'b1;
                en_hi  = 1'b1;
            end
            MODE_DUAL5: begin
                idx_lo = {1'b0, din[7:6], din[2:0]};
                idx_hi = {1'b1, din[7:6], din[5:3]};
                en_lo  = 1'b1;
                en_hi  = 1'b1;
            end
            MODE_TWIN6: begin
                idx_lo = {din[5:4], din[3:0]};
                idx_hi = {din[7:6], din[3:0]};
                en_lo  = 1'b1;
                en_hi  = 1'b1;
            end
            default: begin
                en_lo = 1'b0;
                en_hi = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/frac_lut8_mux.sv
module frac_lut8_mux #(
    parameter int K = 6
) (
    input  logic [(1<<K)-1:0] mask,
    input  logic [K-1:0]      sel,
    output logic              y
);

    localparam int N = 1 << K;

    // heap-ordered tree: node 0 is the root, leaves sit at N-1 .. 2N-2
    logic [2*N-2:0] node;

    assign node[2*N-2:N-1] = mask;

    for (genvar d = 0; d < K; d++) begin : g_lvl
        for (genvar m = 0; m < (1 << d); m++) begin : g_node
            localparam int IDX = (1 << d) - 1 + m;
            assign node[IDX] = sel[K-1-d] ? node[2*IDX+2] : node[2*IDX+1];
        end
    end

    assign y = node[0];

endmodule

// File: rtl/frac_lut8.sv
module frac_lut8
    import frac_lut8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              cfg_din,
    input  logic              ce,
    input  logic [NUM_IN-1:0] din,
    output logic [1:0]        comb_o,
    output logic [1:0]        reg_o
);

    lut_cfg_t         cfg;
    logic [LUT_K-1:0] idx [NUM_OUT];
    logic             en  [NUM_OUT];
    logic             raw [NUM_OUT];
    lut_regs_t        st_d, st_q;

    frac_lut8_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .cfg_en  (cfg_en),
        .cfg_din (cfg_din),
        .cfg     (cfg)
    );

    frac_lut8_route u_route (
        .mode   (cfg.mode),
        .din    (din),
        .idx_lo (idx[0]),
        .idx_hi (idx[1]),
        .en_lo  (en[0]),
        .en_hi  (en[1])
    );

    for (genvar h = 0; h < NUM_OUT; h++) begin : g_half
        frac_lut8_mux #(.K(LUT_K)) u_mux (
            .mask (cfg.mask),
            .sel  (idx[h]),
            .y    (raw[h])
        );
        assign comb_o[h] = en[h] & raw[h];
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.reg_out = '0;
        end else if (ce && !cfg_en) begin
            st_d.reg_out = comb_o;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign reg_o = st_q.reg_out;

    AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (ce && !cfg_en) |=> (reg_o == $past(comb_o))); // R10

    AST_REG_HOLD_CFG: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> $stable(reg_o)); // R10

    AST_REG_HOLD_CE: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(reg_o)); // R10

    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_OFF6 || cfg.mode == MODE_OFF7) |-> (comb_o == 2'b00)); // R9

    AST_L6_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_L6) |-> !comb_o[1]); // R3

    AST_TWIN_MATCH: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_TWIN6 && din[5:4] == din[7:6]) |-> (comb_o[0] == comb_o[1])); // R8

endmodule

// File: tb/frac_lut8_bench.sv
module frac_lut8_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic       ce = 1'b0;
    logic [7:0] din = '0;
    logic [1:0] comb_o;
    logic [1:0] reg_o;

    int         n_chk = 0;
    int         n_bad = 0;
    logic [1:0] exp_reg = 2'b00;

    always #2.5 clk = ~clk;

    frac_lut8 u_frac_lut8 (
        .clk     (clk),
        .rst     (rst),
        .cfg_en  (cfg_en),
        .cfg_din (cfg_din),
        .ce      (ce),
        .din     (din),
        .comb_o  (comb_o),
        .reg_o   (reg_o)
    );

    function automatic logic [1:0] model(logic [63:0] m, logic [2:0] md, logic [7:0] x);
        logic [1:0] r;
        case (md)
            3'd0: r = {1'b0, m[int'(x[5:0])]};
            3'd1: r = {m[32 + int'(x[7:4])], m[int'(x[3:0])]};
            3'd2: r = {m[32 + int'(x[7:5])], m[int'(x[4:0])]};
            3'd3: r = {m[32 + int'({x[7], x[6:4]})], m[int'({x[7], x[3:0]})]};
            3'd4: r = {m[32 + int'({x[7:6], x[5:3]})], m[int'({x[7:6], x[2:0]})]};
            3'd5: r = {m[int'({x[7:6], x[3:0]})], m[int'({x[5:4], x[3:0]})]};
            default: r = 2'b00;
        endcase
        return r;
    endfunction

    function automatic string mode_tag(logic [2:0] md);
        case (md)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(logic ok, string tag, logic [1:0] act, logic [1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // serial load; registers must hold throughout (R1, R10)
    task automatic load(logic [63:0] m, logic [2:0] md);
        logic [66:0] bits;
        bits = {md, m};
        for (int b = 0; b < 67; b++) begin
            @(negedge clk);
            check(reg_o == exp_reg, "R10", reg_o, exp_reg);
            cfg_en  = 1'b1;
            cfg_din = bits[b];
            ce      = 1'($urandom % 2);
        end
        @(negedge clk);
        check(reg_o == exp_reg, "R10", reg_o, exp_reg);
        cfg_en = 1'b0;
        ce     = 1'b0;
    endtask

    task automatic sweep(logic [63:0] m, logic [2:0] md);
        logic [1:0] e;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            check(reg_o == exp_reg, "R10", reg_o, exp_reg);
            din = 8'(i);
            ce  = 1'($urandom % 2);
            #1;
            e = model(m, md, din);
            check(comb_o == e, mode_tag(md), comb_o, e);
            if (ce) exp_reg = e;
        end
    endtask

    initial begin
        logic [63:0] m;
        logic        f;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(reg_o == 2'b00, "R10", reg_o, 2'b00);
        // after reset the mode is 7: outputs zero (R9)
        for (int i = 0; i < 16; i++) begin
            din = 8'($urandom);
            #1;
            check(comb_o == 2'b00, "R9", comb_o, 2'b00);
        end

        for (int md = 0; md < 8; md++) begin
            for (int k = 0; k < 3; k++) begin
                m = (k == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : {$urandom, $urandom};
                load(m, 3'(md));
                sweep(m, 3'(md));
            end
        end

        // directed mask-order case (R2)
        m = {48'h5A5A_0F0F_3C3C, 16'h8009};
        load(m, 3'd1);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            din = {4'b1010, 4'(i)};
            #1;
            f = (!din[0] && !din[1] && !din[2] && !din[3]) ||
                (din[0] && din[1] && din[2] && din[3]) ||
                (din[0] && din[1] && !din[2] && !din[3]);
            check(comb_o[0] == f, "R2", comb_o, {comb_o[1], f});
        end
        // one-bit mask walk confirms bit 0 arrives first (R1)
        m = 64'h0000_0000_0000_0001;
        load(m, 3'd0);
        sweep(m, 3'd0);

        // make registers non-zero, then reset with ce high (R10, R9)
        @(negedge clk);
        din = 8'h00;
        ce  = 1'b1;
        @(negedge clk);
        check(reg_o == 2'b01, "R10", reg_o, 2'b01);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(reg_o == 2'b00, "R10", reg_o, 2'b00);
        check(comb_o == 2'b00, "R9", comb_o, 2'b00);
        ce = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule